// File: doc/BRIEF.md
# JTAG-to-SPI Flash Bridge

This block hangs off a user instruction of a JTAG TAP and turns the TAP's data-register path into a serial link to an external SPI flash. While the user instruction is loaded and the TAP is shifting DR, every TCK is one shift step. TDI feeds the flash's MOSI line. The flash's MISO comes back on TDO. TCK itself, gated, is the SPI clock.

Each transfer is framed in the TDI stream. Any run of zeros ends at the first 1, called the start bit. Zeros of this kind come from bypass registers in front of the bridge. The start bit is followed by a 32-bit burst length, most significant bit first. Chip select is then held low for exactly that many SPI clocks. After the burst, any further shifting is harmless. This lets the returned MISO bits pass through the TAPs further down the chain.

The host does an IR scan and a DR capture before each transfer. Outside a burst, the bridge looks like a 1-bit data register to the chain.

Top module: `jtag_spi_bridge`

## Requirements
- R1: A synchronous reset, sampled on TCK, sets spi_cs_n high and sets spi_sck and tdo low.
- R2: While idle and shifting, TDI zeros are ignored. A frame starts only on the first TDI 1.
- R3: The 32 TDI bits after the start bit form the burst length N, first bit most significant. spi_sck then gives exactly N rising edges.
- R4: At every spi_sck rising edge, spi_mosi equals the TDI value presented in that cycle.
- R5: spi_sck is low whenever spi_cs_n is high, and it idles low.
- R6: Outside a burst, the bridge is a 1-bit DR. tdo, updated on the TCK falling edge, shows the TDI value taken at the preceding rising edge.
- R7: During a burst, tdo, updated on the falling edge, shows the spi_miso value taken at the preceding rising edge.
- R8: spi_cs_n goes low at the falling edge after the last length bit. It goes high at the falling edge after the Nth burst clock. It stays high through any further shifting.
- R9: Leaving Shift-DR or dropping the select input aborts the frame. No further SPI clocks occur, spi_cs_n rises at the next falling edge, and the bridge waits for a new start bit.
- R10: A length of zero ends the frame without ever driving spi_cs_n low.
- R11: A capture (or update) indication while selected clears the frame and loads 0 into the 1-bit DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock, also the source of the SPI clock |
| rst | input | 1 | Synchronous active-high reset |
| usr_sel | input | 1 | High while the bridge's user instruction is in IR |
| cap_dr | input | 1 | TAP is in Capture-DR |
| shf_dr | input | 1 | TAP is in Shift-DR |
| upd_dr | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial data from the JTAG chain |
| tdo | output | 1 | Serial data to the JTAG chain, changes on falling TCK |
| spi_sck | output | 1 | Gated SPI clock, mode 0 |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_cs_n | output | 1 | Active-low flash chip select |
| spi_miso | input | 1 | SPI data from the flash |

## Verification
A wrong framing state shows at the ports within one TCK. A missed or spurious start bit shifts the chip-select window by whole cycles. A mis-ordered or mis-counted length changes the number of SPI clock edges, so the edge count per frame is compared with the decoded length. A wrong DR source during or outside the burst is visible on tdo half a cycle after the edge that took it, so every shifted bit's tdo is compared. Aborts are checked by counting the clocks that reach the flash after Shift-DR or the select input drops.

// File: rtl/jsb_pkg.sv
package jsb_pkg;
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_LEN   = 2'd1,
    ST_BURST = 2'd2,
    ST_DONE  = 2'd3
  } jsb_state_e;
endpackage

// File: rtl/jsb_frame.sv
module jsb_frame #(
  parameter int LEN_W = 32
) (
  input  logic tck,
  input  logic rst,
  input  logic clear,
  input  logic tdi,
  output logic burst
);
  import jsb_pkg::*;

  localparam int BC_W = (LEN_W > 1) ? $clog2(LEN_W) : 1;
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(LEN_W - 1);

  jsb_state_e       st;
  logic [BC_W-1:0]  bitc;
  logic [LEN_W-1:0] len_sr;
  logic [LEN_W-1:0] len_nx;
  logic [LEN_W-1:0] remain;

  assign len_nx = {len_sr[LEN_W-2:0], tdi};

  always_ff @(posedge tck) begin
    if (rst || clear) begin
      st     <= ST_HUNT;
      bitc   <= '0;
      len_sr <= '0;
      remain <= '0;
    end else begin
      case (st)
        ST_HUNT: begin
          if (tdi) begin
            st     <= ST_LEN;
            bitc   <= '0;
            len_sr <= '0;
          end
        end
        ST_LEN: begin
          len_sr <= len_nx;
          if (bitc == BC_LAST) begin
            remain <= len_nx;
            st     <= (len_nx == '0) ? ST_DONE : ST_BURST;
          end else begin
            bitc <= bitc + 1'b1;
          end
        end
        ST_BURST: begin
          remain <= remain - 1'b1;
          if (remain == LEN_W'(1)) st <= ST_DONE;
        end
        default: st <= ST_DONE;
      endcase
    end
  end

  assign burst = (st == ST_BURST);

  // R2: zeros while hunting never start a frame
  a_r2_wait_marker: assert property (@(posedge tck) disable iff (rst)
    (st == ST_HUNT && !clear && !tdi) |=> (st == ST_HUNT));

  // R9: abort returns to hunting
  a_r9_abort_hunt: assert property (@(posedge tck) disable iff (rst)
    clear |=> (st == ST_HUNT));

  // R3: last counted clock ends the burst
  a_r3_count_end: assert property (@(posedge tck) disable iff (rst)
    (st == ST_BURST && !clear && remain == LEN_W'(1)) |=> (st == ST_DONE));

  // R10: zero length skips the burst
  a_r10_zero_len: assert property (@(posedge tck) disable iff (rst)
    (st == ST_LEN && !clear && bitc == BC_LAST && len_nx == '0) |=> (st == ST_DONE));

  // R8: finished frame stays finished while shifting
  a_r8_done_holds: assert property (@(posedge tck) disable iff (rst)
    (st == ST_DONE && !clear) |=> (st == ST_DONE));
endmodule

// File: rtl/jsb_drbit.sv
module jsb_drbit (
  input  logic tck,
  input  logic rst,
  input  logic load_zero,
  input  logic shifting,
  input  logic burst,
  input  logic tdi,
  input  logic miso,
  output logic tdo
);
  logic dr_q;
  logic tdo_q;

  always_ff @(posedge tck) begin
    if (rst)            dr_q <= 1'b0;
    else if (load_zero) dr_q <= 1'b0;
    else if (shifting)  dr_q <= burst ? miso : tdi;
  end

  always_ff @(negedge tck) begin
    if (rst) tdo_q <= 1'b0;
    else     tdo_q <= dr_q;
  end

  assign tdo = tdo_q;

  // R11: capture leaves a zero in the DR bit
  a_r11_cap_zero: assert property (@(posedge tck) disable iff (rst)
    load_zero |=> !dr_q);
endmodule

// File: rtl/jsb_sckgate.sv
module jsb_sckgate (
  input  logic tck,
  input  logic rst,
  input  logic burst,
  input  logic shifting,
  output logic sck,
  output logic cs_n
);
  logic gate_q;

  always_ff @(negedge tck) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= burst;
  end

  assign cs_n = ~gate_q;
  assign sck  = tck & gate_q & shifting;

  // R5: a high clock is only seen with chip select low
  a_r5_sck_needs_cs: assert property (@(negedge tck) disable iff (rst)
    sck |-> !cs_n);
endmodule

// File: rtl/jtag_spi_bridge.sv
module jtag_spi_bridge #(
  parameter int LEN_W = 32
) (
  input  logic tck,
  input  logic rst,
  input  logic usr_sel,
  input  logic cap_dr,
  input  logic shf_dr,
  input  logic upd_dr,
  input  logic tdi,
  output logic tdo,
  output logic spi_sck,
  output logic spi_mosi,
  output logic spi_cs_n,
  input  logic spi_miso
);
  logic shifting;
  logic clear;
  logic burst;

  assign shifting = usr_sel & shf_dr;
  assign clear    = ~shifting | (usr_sel & (cap_dr | upd_dr));

  jsb_frame #(.LEN_W(LEN_W)) u_frame (
    .tck   (tck),
    .rst   (rst),
    .clear (clear),
    .tdi   (tdi),
    .burst (burst)
  );

  jsb_drbit u_dr (
    .tck       (tck),
    .rst       (rst),
    .load_zero (usr_sel & cap_dr),
    .shifting  (shifting),
    .burst     (burst),
    .tdi       (tdi),
    .miso      (spi_miso),
    .tdo       (tdo)
  );

  jsb_sckgate u_gate (
    .tck      (tck),
    .rst      (rst),
    .burst    (burst),
    .shifting (shifting),
    .sck      (spi_sck),
    .cs_n     (spi_cs_n)
  );

  assign spi_mosi = tdi;

  // R9: after an abort edge the select is released at the next falling edge
  a_r9_cs_release: assert property (@(posedge tck) disable iff (rst)
    (!shifting && !burst) |=> spi_cs_n);
endmodule

// File: tb/tb_jtag_spi_bridge.sv
module tb_jtag_spi_bridge;
  logic tck = 1'b0;
  logic rst = 1'b1;
  logic usr_sel = 1'b0, cap_dr = 1'b0, shf_dr = 1'b0, upd_dr = 1'b0;
  logic tdi = 1'b0, spi_miso = 1'b0;
  logic tdo, spi_sck, spi_mosi, spi_cs_n;

  int total = 0, bad = 0;
  int pulses = 0, mosi_bad = 0, sckcs_bad = 0;
  bit finished = 0;

  always #5 tck = ~tck;

  jtag_spi_bridge dut (
    .tck(tck), .rst(rst), .usr_sel(usr_sel), .cap_dr(cap_dr), .shf_dr(shf_dr),
    .upd_dr(upd_dr), .tdi(tdi), .tdo(tdo), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso)
  );

  always @(posedge spi_sck) begin
    pulses++;
    if (spi_mosi !== tdi) mosi_bad++;
    if (spi_cs_n !== 1'b0) sckcs_bad++;
  end

  localparam int NV = 5;
  localparam int VZ [NV] = '{0, 3, 5, 1, 2};
  localparam int VN [NV] = '{1, 6, 0, 17, 2};
  localparam int VT [NV] = '{3, 4, 2, 5, 3};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive after a falling edge, sample after the next falling edge
  task automatic step(input logic t, input logic m, output logic o_tdo, output logic o_cs);
    tdi = t;
    spi_miso = m;
    @(posedge tck);
    @(negedge tck);
    #1;
    o_tdo = tdo;
    o_cs = spi_cs_n;
  endtask

  task automatic run_frame(input int z, input int n, input int tl, input int cut, input bit by_sel);
    int nbits, p0, tdo_err, cs_err, cs_low;
    logic o, c;
    nbits = (cut >= 0) ? z + 33 + cut : z + 33 + n + tl;
    tdo_err = 0; cs_err = 0; cs_low = 0;
    usr_sel = 1; cap_dr = 1; shf_dr = 0;
    step(0, 0, o, c);
    cap_dr = 0; shf_dr = 1;
    p0 = pulses;
    for (int i = 0; i < nbits; i++) begin
      logic tb, mb, etdo, ecs;
      bit in_b;
      if (i < z) tb = 0;
      else if (i == z) tb = 1;
      else if (i <= z + 32) tb = logic'((n >> (32 - (i - z))) & 1);
      else tb = logic'(((i * 3) >> 2) & 1);
      mb = logic'(((i * 5) >> 1) & 1);
      in_b = (n > 0) && (i > z + 32) && (i <= z + 32 + n);
      step(tb, mb, o, c);
      etdo = in_b ? mb : tb;
      ecs = !((n > 0) && (i >= z + 32) && (i < z + 32 + n));
      if (o !== etdo) tdo_err++;
      if (c !== ecs) cs_err++;
      if (c === 1'b0) cs_low++;
    end
    if (cut >= 0) begin
      if (by_sel) usr_sel = 0; else shf_dr = 0;
      step(1, 1, o, c);
      check(c === 1'b1, "R9 cs_n after abort", int'(c), 1);
      step(1, 1, o, c);
      check(pulses - p0 == cut, "R9 clocks up to abort", pulses - p0, cut);
      usr_sel = 1;
    end else begin
      check(pulses - p0 == n, "R2 R3 sck edges per frame", pulses - p0, n);
      check(tdo_err == 0, "R6 R7 tdo stream mismatches", tdo_err, 0);
      check(cs_err == 0, "R8 cs_n window mismatches", cs_err, 0);
      if (n == 0) check(cs_low == 0, "R10 cs_n low cycles", cs_low, 0);
    end
    shf_dr = 0; upd_dr = 1;
    step(0, 0, o, c);
    upd_dr = 0;
    step(0, 0, o, c);
    check(c === 1'b1 && spi_sck === 1'b0, "R5 idle after frame", int'(spi_sck), 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic o, c;
    repeat (3) @(negedge tck);
    #1;
    check(spi_cs_n === 1'b1, "R1 cs_n in reset", int'(spi_cs_n), 1);
    check(spi_sck === 1'b0, "R1 sck in reset", int'(spi_sck), 0);
    check(tdo === 1'b0, "R1 tdo in reset", int'(tdo), 0);
    rst = 0;
    step(0, 0, o, c);

    for (int v = 0; v < NV; v++) run_frame(VZ[v], VN[v], VT[v], -1, 0);

    run_frame(2, 10, 0, 4, 0);   // R9 abort by leaving shift
    run_frame(1, 9, 0, 3, 1);    // R9 abort by dropping select
    run_frame(0, 3, 2, -1, 0);   // frame after aborts still counts

    // R11: DR bit holds a 1, then capture loads 0
    usr_sel = 1; shf_dr = 1;
    step(1, 0, o, c);
    step(1, 0, o, c);
    check(o === 1'b1, "R6 bypass bit", int'(o), 1);
    shf_dr = 0; cap_dr = 1;
    step(1, 0, o, c);
    check(o === 1'b0, "R11 capture clears DR", int'(o), 0);
    cap_dr = 0;
    step(0, 0, o, c);

    check(mosi_bad == 0, "R4 mosi at sck edges", mosi_bad, 0);
    check(sckcs_bad == 0, "R5 sck with cs_n high", sckcs_bad, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule